// File: doc/BRIEF.md
# Sprite Per-Line Overflow Status

This block watches the per-scanline activity of a tile-based sprite engine and reports two sticky overflow conditions. The sprite evaluator sends one pulse for every sprite found to lie on the current line, together with that sprite's OAM index. The tile fetcher sends one pulse for every 8-pixel sprite sliver it fetches for the line. A 16-pixel-wide sprite therefore arrives as two tile pulses. The block also receives the beam position (H and V counts), a pulse marking the end of vertical blank, and a forced-blank level.

For each line, two saturating counters tally sprites and tiles. The range flag is raised when a line holds more than 32 sprites. The time flag is raised when a line holds more than 34 tiles. Each flag is raised at a fixed beam position. Both flags stay set across lines and fields until a vertical-blank-end pulse arrives outside forced blank. Both are computed whether or not sprites are being displayed. They are presented in a status byte together with a master/slave strap input and a fixed version number.

Top module: `sprite_ovf_status`

## Requirements
- R1: The range flag (status bit 6) is set by the 33rd sprite-in-range pulse on a line. Thirty-two pulses on a line leave it clear.
- R2: The time flag (status bit 7) is set when a line receives 35 or more tile pulses. Exactly 34 tile pulses leave it clear.
- R3: A vertical-blank-end pulse clears both flags when forced blank is low. While forced blank is high, the pulse leaves both flags unchanged.
- R4: For the 33rd sprite with OAM index n, the range flag rises on the clock edge where h_cnt_i equals 2*n, and not before. If H never reaches 2*n before the line ends, the flag rises on the clock edge of the line change.
- R5: The time flag rises on the clock edge where the line changes (v_cnt_i differs from its value on the previous cycle). It stays clear while the offending line is still in progress.
- R6: The status byte is {time flag, range flag, master_i, 1'b0, version}, with bit 7 first. The version nibble defaults to 4'h1.
- R7: Once set, a flag stays set across any number of line changes and any other input activity, until the clear of R3.
- R8: Both per-line counters saturate. For example, 66 tile pulses on one line still set the time flag.
- R9: Both counters restart at every line change. A pulse arriving on the cycle of the change counts toward the new line, so 20 tiles on each of two consecutive lines set no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| h_cnt_i | input | 9 | Current horizontal beam count |
| v_cnt_i | input | 9 | Current vertical beam count; a change marks a new line |
| spr_hit_i | input | 1 | One pulse per sprite found on the current line |
| spr_idx_i | input | 7 | OAM index of the sprite accompanying spr_hit_i |
| tile_i | input | 1 | One pulse per sprite tile fetched for the current line |
| vblank_end_i | input | 1 | Pulse at the end of vertical blank |
| fblank_i | input | 1 | Forced-blank level |
| master_i | input | 1 | Master/slave strap reflected in the status byte |
| status_o | output | 8 | Status byte |

## Verification
The embedded assertions check several rules on every cycle. A flag never falls while forced blank is high. A flag never falls without a vertical-blank-end pulse. The range flag rises only after the sprite counter reaches its threshold, and the time flag rises only at a line change that follows an over-full tile count. A saturated counter never wraps within a line. The directed scenarios are needed to show the exact thresholds (32 against 33 sprites, 34 against 35 tiles), the H position at which the range flag rises, the fall-back at the line change, and the layout of the status byte, since these depend on the expected cycle and value.

// File: rtl/sprite_ovf_pkg.sv
package sprite_ovf_pkg;
  localparam int unsigned H_W      = 9;
  localparam int unsigned IDX_W    = 7;
  localparam int unsigned MAX_SPR  = 32;
  localparam int unsigned MAX_TILE = 34;
  localparam logic [3:0]  VERSION  = 4'h1;

  typedef struct packed {
    logic time_ovf;
    logic range_ovf;
    logic master;
    logic rsvd;
    logic [3:0] version;
  } status_t;
endpackage

// File: rtl/sprite_ovf_sat_cnt.sv
module sprite_ovf_sat_cnt #(
  parameter int unsigned MAX = 32,
  localparam int unsigned SAT = MAX + 1,
  localparam int unsigned W   = $clog2(MAX + 2)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= inc_i ? W'(1) : '0;
    else if (inc_i && cnt_q != W'(SAT)) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  // R8: a saturated count holds until the line clears it
  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == W'(SAT) && !clr_i) |=> cnt_o == W'(SAT));
endmodule

// File: rtl/sprite_ovf_range_pend.sv
module sprite_ovf_range_pend #(
  parameter int unsigned H_W   = 9,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [H_W-1:0]   h_cnt_i,
  output logic             fire_o
);
  localparam int unsigned PAD = H_W - IDX_W - 1;

  logic             pend_q;
  logic [IDX_W-1:0] idx_q;
  logic [H_W-1:0]   tgt_new, tgt_old;
  logic             fire_new, fire_old;

  assign tgt_new  = {{PAD{1'b0}}, idx_i, 1'b0};
  assign tgt_old  = {{PAD{1'b0}}, idx_q, 1'b0};
  assign fire_new = hit_i && (h_cnt_i == tgt_new);
  // a pending overflow is committed at its position or, at the latest, at the line change
  assign fire_old = pend_q && ((h_cnt_i == tgt_old) || line_start_i);
  assign fire_o   = fire_new || fire_old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      idx_q  <= '0;
    end else if (fire_o || line_start_i) begin
      pend_q <= 1'b0;
    end else if (hit_i) begin
      pend_q <= 1'b1;
      idx_q  <= idx_i;
    end
  end

  // R4: a pending overflow never survives a line change
  a_r4_pend_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> !pend_q);
endmodule

// File: rtl/sprite_ovf_status.sv
module sprite_ovf_status
  import sprite_ovf_pkg::*;
#(
  parameter int unsigned HW     = H_W,
  parameter int unsigned IW     = IDX_W,
  parameter int unsigned SPR_TH = MAX_SPR,
  parameter int unsigned TIL_TH = MAX_TILE,
  parameter logic [3:0]  VER    = VERSION,
  localparam int unsigned SW    = $clog2(SPR_TH + 2),
  localparam int unsigned TW    = $clog2(TIL_TH + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] h_cnt_i,
  input  logic [HW-1:0] v_cnt_i,
  input  logic          spr_hit_i,
  input  logic [IW-1:0] spr_idx_i,
  input  logic          tile_i,
  input  logic          vblank_end_i,
  input  logic          fblank_i,
  input  logic          master_i,
  output logic [7:0]    status_o
);
  logic [HW-1:0] v_q;
  logic          line_start;
  logic [SW-1:0] spr_cnt;
  logic [TW-1:0] tile_cnt;
  logic          range_hit, range_fire, time_fire, clr;
  logic          range_q, time_q;
  status_t       stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= '0;
    else         v_q <= v_cnt_i;
  end
  assign line_start = (v_cnt_i != v_q);

  sprite_ovf_sat_cnt #(.MAX(SPR_TH)) u_spr_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(line_start),
    .inc_i (spr_hit_i), .cnt_o(spr_cnt)
  );

  sprite_ovf_sat_cnt #(.MAX(TIL_TH)) u_tile_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(line_start),
    .inc_i (tile_i), .cnt_o(tile_cnt)
  );

  // the pulse that takes the count past the threshold on the current line
  assign range_hit = spr_hit_i && !line_start && (spr_cnt == SW'(SPR_TH));

  sprite_ovf_range_pend #(.H_W(HW), .IDX_W(IW)) u_range_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_start_i(line_start),
    .hit_i       (range_hit),
    .idx_i       (spr_idx_i),
    .h_cnt_i     (h_cnt_i),
    .fire_o      (range_fire)
  );

  assign time_fire = line_start && (tile_cnt > TW'(TIL_TH));
  assign clr       = vblank_end_i && !fblank_i;

  // a set on the same edge as a clear takes priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      range_q <= 1'b0;
      time_q  <= 1'b0;
    end else begin
      range_q <= range_fire | (range_q & ~clr);
      time_q  <= time_fire  | (time_q  & ~clr);
    end
  end

  always_comb begin
    stat.time_ovf  = time_q;
    stat.range_ovf = range_q;
    stat.master    = master_i;
    stat.rsvd      = 1'b0;
    stat.version   = VER;
  end
  assign status_o = stat;

  // R3: forced blank protects both flags
  a_r3_fblank_hold_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fblank_i |=> !$fell(time_q));
  a_r3_fblank_hold_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fblank_i |=> !$fell(range_q));
  // R7: nothing but the end-of-vblank pulse drops a flag
  a_r7_sticky_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_end_i |=> !$fell(time_q));
  a_r7_sticky_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_end_i |=> !$fell(range_q));
  // R1: the range flag needs a full sprite count behind it
  a_r1_range_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(range_q) |-> $past(spr_cnt >= SW'(SPR_TH)));
  // R2 / R5: the time flag rises only at a line change after an over-full line
  a_r2_time_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(time_q) |-> $past(line_start && tile_cnt > TW'(TIL_TH)));
endmodule

// File: tb/sprite_ovf_status_tb_top.sv
module sprite_ovf_status_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] h_cnt_i = '0;
  logic [8:0] v_cnt_i = '0;
  logic       spr_hit_i = 1'b0;
  logic [6:0] spr_idx_i = '0;
  logic       tile_i = 1'b0;
  logic       vblank_end_i = 1'b0;
  logic       fblank_i = 1'b0;
  logic       master_i = 1'b0;
  logic [7:0] status_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  sprite_ovf_status dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .h_cnt_i(h_cnt_i), .v_cnt_i(v_cnt_i),
    .spr_hit_i(spr_hit_i), .spr_idx_i(spr_idx_i), .tile_i(tile_i),
    .vblank_end_i(vblank_end_i), .fblank_i(fblank_i), .master_i(master_i),
    .status_o(status_o)
  );

  function automatic logic [7:0] exp_stat(input logic t, input logic r);
    return {t, r, master_i, 1'b0, 4'h1};
  endfunction

  task automatic chk(input string req, input logic t, input logic r);
    checks++;
    if (status_o !== exp_stat(t, r)) begin
      fails++;
      $display("FAIL %s status actual=%h expected=%h", req, status_o, exp_stat(t, r));
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic new_line(input logic [8:0] v);
    v_cnt_i = v;
    h_cnt_i = '0;
    tick();
  endtask

  task automatic sprites(input int n, input int first_idx);
    for (int k = 0; k < n; k++) begin
      h_cnt_i   = 9'(k);
      spr_idx_i = 7'(first_idx + k);
      spr_hit_i = 1'b1;
      tick();
    end
    spr_hit_i = 1'b0;
  endtask

  task automatic tiles(input int n);
    tile_i = 1'b1;
    for (int k = 0; k < n; k++) tick();
    tile_i = 1'b0;
  endtask

  task automatic wipe();
    fblank_i = 1'b0;
    vblank_end_i = 1'b1;
    tick();
    vblank_end_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R6 reset", 1'b0, 1'b0);
    master_i = 1'b1;
    #1 chk("R6 master bit", 1'b0, 1'b0);
    master_i = 1'b0;
  endtask

  task automatic t_range_32();
    new_line(9'd10);
    sprites(32, 0);
    h_cnt_i = 9'd200;
    tick();
    chk("R1 32 sprites", 1'b0, 1'b0);
    new_line(9'd11);
    chk("R1 32 sprites after line", 1'b0, 1'b0);
  endtask

  task automatic t_range_33_pos();
    // 33rd sprite gets index 40 -> position H=80
    new_line(9'd20);
    sprites(33, 8);
    h_cnt_i = 9'd79;
    tick();
    chk("R4 before position", 1'b0, 1'b0);
    h_cnt_i = 9'd80;
    tick();
    chk("R4 at position", 1'b0, 1'b1);
    new_line(9'd21);
    new_line(9'd22);
    chk("R7 range sticky", 1'b0, 1'b1);
    wipe();
    chk("R3 range cleared", 1'b0, 1'b0);
  endtask

  task automatic t_range_line_end();
    // 33rd sprite gets index 100 -> H=200, never reached
    new_line(9'd30);
    sprites(33, 68);
    h_cnt_i = 9'd150;
    tick();
    chk("R4 pending not yet", 1'b0, 1'b0);
    new_line(9'd31);
    chk("R4 commit at line change", 1'b0, 1'b1);
    wipe();
  endtask

  task automatic t_time_34_35();
    new_line(9'd40);
    tiles(34);
    new_line(9'd41);
    chk("R2 34 tiles", 1'b0, 1'b0);
    tiles(35);
    h_cnt_i = 9'd300;
    tick();
    chk("R5 not during line", 1'b0, 1'b0);
    new_line(9'd42);
    chk("R2 R5 35 tiles", 1'b1, 1'b0);
  endtask

  task automatic t_fblank();
    fblank_i = 1'b1;
    vblank_end_i = 1'b1;
    tick();
    vblank_end_i = 1'b0;
    chk("R3 fblank keeps flag", 1'b1, 1'b0);
    new_line(9'd43);
    chk("R7 time sticky", 1'b1, 1'b0);
    fblank_i = 1'b0;
    wipe();
    chk("R3 time cleared", 1'b0, 1'b0);
  endtask

  task automatic t_saturate();
    new_line(9'd50);
    tiles(66);
    new_line(9'd51);
    chk("R8 66 tiles", 1'b1, 1'b0);
    wipe();
  endtask

  task automatic t_per_line();
    new_line(9'd60);
    tiles(20);
    new_line(9'd61);
    tiles(20);
    new_line(9'd62);
    chk("R9 tiles per line", 1'b0, 1'b0);
    sprites(20, 0);
    new_line(9'd63);
    sprites(20, 0);
    h_cnt_i = 9'd250;
    tick();
    new_line(9'd64);
    chk("R9 sprites per line", 1'b0, 1'b0);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_range_32();
    t_range_33_pos();
    t_range_line_end();
    t_time_34_35();
    t_fblank();
    t_saturate();
    t_per_line();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule